// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block sits next to one processor's load/store unit and holds that processor's exclusive reservation. A load-exclusive arms a single tag and records the address and access size it used. A later store-exclusive is checked against the tag and the record. The block returns a one-bit status for the register file and a gated write enable for memory, so the store reaches memory only when the reservation still holds.

The reservation is dropped by every store-exclusive, whatever its outcome. A clear-exclusive command and exception entry also drop it. Software running a read-modify-write or semaphore claim must therefore retry after any interruption. The pipeline, the register file and memory are outside the block. The block sees only decoded strobes with an address and a size code.

Top module: `excl_monitor`

## Requirements
- R1: After reset the tag is clear and all outputs are 0, so a store-exclusive with no earlier load-exclusive fails (status 1, no write enable).
- R2: `st_valid_o` is 1 exactly in the cycle after a cycle with `st_excl_i` high. `st_fail_o` and `mem_we_o` are 0 whenever `st_valid_o` is 0.
- R3: A load-exclusive with a legal size sets the tag and records its address and size code.
- R4: A store-exclusive that finds the tag set and the same address and size code returns status 0 and raises `mem_we_o` for one cycle.
- R5: A store-exclusive fails (status 1, no write enable) when its address or its size code differs from the recorded one, even with the tag set.
- R6: Every store-exclusive clears the tag, whether it passes or fails, so an immediate second store-exclusive fails.
- R7: A clear-exclusive command clears the tag.
- R8: Exception entry clears the tag. An exception in the same cycle as a store-exclusive makes that store fail.
- R9: A load-exclusive while the tag is already set replaces the recorded address and size and leaves the tag set.
- R10: A clear-exclusive in the same cycle as a store-exclusive makes the store fail. A load-exclusive in the same cycle as a store-exclusive, clear-exclusive or exception is ignored, and the tag ends clear. In that case the store is judged on the state from before the cycle.
- R11: Size codes are 0 byte, 1 halfword, 2 word. Code 3 is reserved: a load-exclusive with code 3 leaves the tag and record unchanged, and a store-exclusive with code 3 never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_excl_i | input | 1 | Load-exclusive strobe |
| st_excl_i | input | 1 | Store-exclusive strobe |
| clr_excl_i | input | 1 | Clear-exclusive command strobe |
| exc_entry_i | input | 1 | Exception entry strobe |
| addr_i | input | ADDR_W | Address of the exclusive access |
| size_i | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| st_valid_o | output | 1 | Store-exclusive result valid, one cycle after the strobe |
| st_fail_o | output | 1 | Store-exclusive status: 0 passed, 1 failed |
| mem_we_o | output | 1 | Gated write enable for memory |

## Verification
The bench sweeps every pairing of load and store size codes against equal and differing addresses. A monitor that compared only the address, or that let a store of a different size through, would report a pass where the requirements expect a failure. It drives a second store-exclusive straight after both a passing and a failing one. A design that cleared the tag only on success would then wrongly grant the retry. It also drives strobes together in one cycle (store with clear, store with exception, load with store) and a reserved-size load placed between a valid load and its store. Getting the priority wrong would either grant a write through an exception or leave a stale reservation armed.

// File: rtl/excl_pkg.sv
`timescale 1ns/1ps
// Package excl_pkg
// Shared size encoding and helpers for the exclusive monitor.
// Assumes a two-bit size code from the instruction decoder.
package excl_pkg;
    localparam int SIZE_W = 2;

    typedef enum logic [SIZE_W-1:0] {
        XSZ_BYTE = 2'd0,
        XSZ_HALF = 2'd1,
        XSZ_WORD = 2'd2,
        XSZ_RSVD = 2'd3
    } xsize_e;

    // True when the size code names a real access width.
    function automatic logic size_is_legal(input logic [SIZE_W-1:0] code);
        return code != XSZ_RSVD;
    endfunction
endpackage

// File: rtl/excl_tag_store.sv
`timescale 1ns/1ps
// Module excl_tag_store
// Holds the reservation tag with the recorded address and size code.
// Assumes kill_i already merges every clearing event. A clearing event
// outranks a load in the same cycle. Reserved-size loads are ignored.
module excl_tag_store
    import excl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              kill_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              tag_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SIZE_W-1:0] size_o
);
    logic arm;
    assign arm = ld_i && !kill_i && size_is_legal(size_i);

    // Update the tag and the record: clear first, then arm on a legal load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o  <= 1'b0;
            addr_o <= '0;
            size_o <= '0;
        end else if (kill_i) begin
            tag_o  <= 1'b0;
        end else if (arm) begin
            tag_o  <= 1'b1;
            addr_o <= addr_i;
            size_o <= size_i;
        end
    end

    AST_KILL_CLEARS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !tag_o); // R6
    AST_LOAD_ARMS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !kill_i && size_i != 2'd3) |=> (tag_o && addr_o == $past(addr_i) && size_o == $past(size_i))); // R3
    AST_RSVD_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !kill_i && size_i == 2'd3) |=> ($stable(tag_o) && $stable(addr_o) && $stable(size_o))); // R11
endmodule

// File: rtl/excl_match.sv
`timescale 1ns/1ps
// Module excl_match
// Decides whether a store-exclusive may write. Purely combinational.
// Assumes the record comes from excl_tag_store in the same cycle.
module excl_match
    import excl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              tag_i,
    input  logic [ADDR_W-1:0] rec_addr_i,
    input  logic [SIZE_W-1:0] rec_size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              abort_i,
    output logic              pass_o
);
    // Pass needs an armed tag, equal address and size, and no abort.
    always_comb begin
        pass_o = tag_i && !abort_i && (rec_addr_i == addr_i)
                 && (rec_size_i == size_i) && size_is_legal(size_i);
    end
endmodule

// File: rtl/excl_resp.sv
`timescale 1ns/1ps
// Module excl_resp
// Registers the store-exclusive result. Status and write enable appear
// one cycle after the strobe and are zero when no result is valid.
module excl_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic st_i,
    input  logic pass_i,
    output logic valid_o,
    output logic fail_o,
    output logic we_o
);
    // Capture the result of this cycle's store-exclusive, if any.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            fail_o  <= 1'b0;
            we_o    <= 1'b0;
        end else begin
            valid_o <= st_i;
            fail_o  <= st_i && !pass_i;
            we_o    <= st_i && pass_i;
        end
    end

    AST_RESULT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        st_i |=> valid_o); // R2
    AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_i |=> (!valid_o && !fail_o && !we_o)); // R2
    AST_WE_XOR_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (we_o != fail_o)); // R4
endmodule

// File: rtl/excl_monitor.sv
`timescale 1ns/1ps
// Module excl_monitor
// Local exclusive access monitor for one processor. It combines the
// clearing events and judges store-exclusives against the reservation.
// Assumes strobes are decoded and each lasts one cycle per access.
module excl_monitor
    import excl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_excl_i,
    input  logic              st_excl_i,
    input  logic              clr_excl_i,
    input  logic              exc_entry_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic              st_valid_o,
    output logic              st_fail_o,
    output logic              mem_we_o
);
    logic              kill;
    logic              abort;
    logic              tag;
    logic              pass;
    logic [ADDR_W-1:0] rec_addr;
    logic [SIZE_W-1:0] rec_size;

    // Every store, clear or exception drops the tag. Clear and exception also abort a store.
    assign kill  = st_excl_i || clr_excl_i || exc_entry_i;
    assign abort = clr_excl_i || exc_entry_i;

    excl_tag_store #(.ADDR_W(ADDR_W)) u_tag (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (ld_excl_i),
        .kill_i (kill),
        .addr_i (addr_i),
        .size_i (size_i),
        .tag_o  (tag),
        .addr_o (rec_addr),
        .size_o (rec_size)
    );

    excl_match #(.ADDR_W(ADDR_W)) u_match (
        .tag_i      (tag),
        .rec_addr_i (rec_addr),
        .rec_size_i (rec_size),
        .addr_i     (addr_i),
        .size_i     (size_i),
        .abort_i    (abort),
        .pass_o     (pass)
    );

    excl_resp u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_i    (st_excl_i),
        .pass_i  (pass),
        .valid_o (st_valid_o),
        .fail_o  (st_fail_o),
        .we_o    (mem_we_o)
    );

    AST_NO_TAG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_excl_i && !tag) |=> (st_fail_o && !mem_we_o)); // R1
    AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_excl_i && (addr_i != rec_addr || size_i != rec_size)) |=> !mem_we_o); // R5
    AST_EXC_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_excl_i && exc_entry_i) |=> st_fail_o); // R8
    AST_CLR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_excl_i && clr_excl_i) |=> st_fail_o); // R10
endmodule

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b0, st = 1'b0, clr = 1'b0, exc = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        st_valid, st_fail, mem_we;

    int checks = 0;
    int errors = 0;

    // Reference model of the reservation, built from the requirements.
    logic        m_tag = 1'b0;
    logic [31:0] m_addr = '0;
    logic [1:0]  m_size = '0;

    always #2 clk = ~clk; // 250 MHz

    excl_monitor #(.ADDR_W(32)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_excl_i   (ld),
        .st_excl_i   (st),
        .clr_excl_i  (clr),
        .exc_entry_i (exc),
        .addr_i      (addr),
        .size_i      (size),
        .st_valid_o  (st_valid),
        .st_fail_o   (st_fail),
        .mem_we_o    (mem_we)
    );

    task automatic op(input logic l, input logic s, input logic c, input logic e,
                      input logic [31:0] a, input logic [1:0] z, input string req);
        logic pass;
        @(negedge clk);
        ld = l; st = s; clr = c; exc = e; addr = a; size = z;
        pass = s && m_tag && !c && !e && (a == m_addr) && (z == m_size) && (z != 2'd3);
        @(posedge clk);
        #1;
        ld = 0; st = 0; clr = 0; exc = 0;
        checks++;
        if (st_valid !== s || st_fail !== (s && !pass) || mem_we !== (s && pass)) begin
            errors++;
            $display("FAIL %s: valid/fail/we = %b%b%b expected %b%b%b", req,
                     st_valid, st_fail, mem_we, s, s && !pass, s && pass);
        end
        if (s || c || e) m_tag = 1'b0;
        else if (l && z != 2'd3) begin
            m_tag = 1'b1; m_addr = a; m_size = z;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (st_valid !== 0 || st_fail !== 0 || mem_we !== 0) begin
            errors++;
            $display("FAIL R1: reset outputs %b%b%b expected 000", st_valid, st_fail, mem_we);
        end
        rst_n = 1'b1;

        // R1: store-exclusive without a prior load fails
        op(0, 1, 0, 0, 32'h100, 2'd2, "R1");
        // R2: idle cycle gives no result
        op(0, 0, 0, 0, 32'h100, 2'd2, "R2");

        // R3 R4 R5 R11: sweep size pairs and address offsets
        for (int ls = 0; ls < 4; ls++)
            for (int ss = 0; ss < 4; ss++)
                for (int d = 0; d < 3; d++) begin
                    op(1, 0, 0, 0, 32'h2000, ls[1:0], "R3");
                    op(0, 1, 0, 0, 32'h2000 + ((d == 0) ? 0 : (d == 1) ? 1 : 4),
                       ss[1:0], "R4_R5_R11");
                end

        // R11: reserved-size load leaves an existing reservation intact
        op(1, 0, 0, 0, 32'h30, 2'd1, "R3");
        op(1, 0, 0, 0, 32'h40, 2'd3, "R11");
        op(0, 1, 0, 0, 32'h30, 2'd1, "R11");

        // R6: second store after a pass, and after a fail
        op(1, 0, 0, 0, 32'h50, 2'd0, "R3");
        op(0, 1, 0, 0, 32'h50, 2'd0, "R6");
        op(0, 1, 0, 0, 32'h50, 2'd0, "R6");
        op(1, 0, 0, 0, 32'h60, 2'd2, "R3");
        op(0, 1, 0, 0, 32'h64, 2'd2, "R6");
        op(0, 1, 0, 0, 32'h60, 2'd2, "R6");

        // R7: clear-exclusive drops the tag
        op(1, 0, 0, 0, 32'h70, 2'd2, "R3");
        op(0, 0, 1, 0, 32'h0, 2'd0, "R7");
        op(0, 1, 0, 0, 32'h70, 2'd2, "R7");

        // R8: exception entry drops the tag, and aborts a coincident store
        op(1, 0, 0, 0, 32'h80, 2'd1, "R3");
        op(0, 0, 0, 1, 32'h0, 2'd0, "R8");
        op(0, 1, 0, 0, 32'h80, 2'd1, "R8");
        op(1, 0, 0, 0, 32'h84, 2'd1, "R3");
        op(0, 1, 0, 1, 32'h84, 2'd1, "R8");

        // R9: reload replaces the record
        op(1, 0, 0, 0, 32'h90, 2'd2, "R3");
        op(1, 0, 0, 0, 32'h94, 2'd2, "R9");
        op(0, 1, 0, 0, 32'h90, 2'd2, "R9");
        op(1, 0, 0, 0, 32'h90, 2'd2, "R3");
        op(1, 0, 0, 0, 32'h98, 2'd0, "R9");
        op(0, 1, 0, 0, 32'h98, 2'd0, "R9");

        // R10: coincident strobes
        op(1, 0, 0, 0, 32'hA0, 2'd2, "R3");
        op(0, 1, 1, 0, 32'hA0, 2'd2, "R10");
        op(1, 0, 0, 0, 32'hB0, 2'd2, "R3");
        op(1, 1, 0, 0, 32'hB0, 2'd2, "R10");
        op(0, 1, 0, 0, 32'hB0, 2'd2, "R10");
        op(1, 0, 1, 0, 32'hC0, 2'd2, "R10");
        op(0, 1, 0, 0, 32'hC0, 2'd2, "R10");
        op(1, 0, 0, 1, 32'hD0, 2'd1, "R10");
        op(0, 1, 0, 0, 32'hD0, 2'd1, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule